// File: doc/BRIEF.md
# Segment Register Bank with Logical Address Former

This block holds the four 16-bit segment registers of a CPU core: code, data, stack and extra. The code segment qualifies instruction addresses. The stack segment qualifies stack accesses. The data segment serves ordinary data, and the extra segment serves string data. Any one register can be loaded from the 32-bit internal CPU bus. A second, independent selector picks which register is presented to the address-translation side.

The selected segment value is joined with a 32-bit offset to form a 48-bit logical address. The segment sits in the upper 16 bits and the offset in the lower 32 bits. When the read enable is low, the segment output is driven to zero and a valid flag drops; this pair takes the place of a tri-stated line.

Control is split from storage. A small decoder turns the select fields and strobes into a one-hot load vector and a drive enable. The datapath holds the registers, the output multiplexer and the address concatenation.

Top module: `segment_file_top`

## Requirements
- R1: A synchronous active-high reset clears all four segment registers to zero.
- R2: Write-select codes map 0 to code, 1 to data, 2 to stack and 3 to extra. Read-select codes use the same mapping. A write strobe loads only the selected register, at the rising clock edge.
- R3: While the write strobe is 0, no segment register changes, whatever the bus and write-select values are.
- R4: A load stores bits 15:0 of the bus; bits 31:16 of the bus have no effect on the stored value.
- R5: While the read enable is 1, the segment output equals the register chosen by the read select and the valid output is 1, in the same cycle.
- R6: While the read enable is 0, the segment output is zero and the valid output is 0.
- R7: The logical address has the segment output in bits 47:32 and the offset input in bits 31:0.
- R8: When a write and a read hit the same register in one cycle, the read returns the value held before the edge. The new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wrSel | input | 2 | Register chosen for loading |
| wrStrobe | input | 1 | Load the chosen register from the bus |
| rdSel | input | 2 | Register chosen for the output |
| rdEn | input | 1 | Drive the chosen register to the output |
| busIn | input | 32 | Internal CPU bus |
| offsetIn | input | 32 | Address offset |
| segOut | output | 16 | Selected segment value, zero when not enabled |
| segValid | output | 1 | High while the segment output is driven |
| logicalAddr | output | 48 | Segment joined with offset |

## Verification
The hardest case to reach is a load and a read of the same register in one cycle, where the output must still show the old contents. The bench gets there by loading a known value, then asserting the strobe with a new value while the read enable and a matching read select are held. It samples the output before the edge and again after it. Writes carry non-zero upper bus bits, and every register gets distinct values over several rounds, so that a mis-decoded select or a wrong bus slice shows up in the readback sweep.

// File: rtl/seg_file_pkg.sv
package seg_file_pkg;
  localparam int SEG_W   = 16;
  localparam int BUS_W   = 32;
  localparam int OFF_W   = 32;
  localparam int NUM_SEG = 4;
  localparam int SEL_W   = $clog2(NUM_SEG);
  localparam int ADDR_W  = SEG_W + OFF_W;

  // Encoding shared by the write and read selects
  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } segId_e;

  typedef struct packed {
    logic [NUM_SEG-1:0] loadVec;
    logic               driveEn;
    logic [SEL_W-1:0]   pickSel;
  } segStrobe_t;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_file_pkg::*;
(
  input  logic [SEL_W-1:0] wrSel,
  input  logic             wrStrobe,
  input  logic [SEL_W-1:0] rdSel,
  input  logic             rdEn,
  output segStrobe_t       strobes
);
  logic [NUM_SEG-1:0] loadDec;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gLoadDec
    assign loadDec[g] = wrStrobe && (wrSel == SEL_W'(g));
  end

  always_comb begin
    strobes.loadVec = loadDec;
    strobes.driveEn = rdEn;
    strobes.pickSel = rdSel;
  end
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_file_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  segStrobe_t        strobes,
  input  logic [SEG_W-1:0]  busLow,
  input  logic [OFF_W-1:0]  offsetIn,
  output logic [SEG_W-1:0]  segOut,
  output logic              segValid,
  output logic [ADDR_W-1:0] logicalAddr
);
  logic [SEG_W-1:0] segReg [NUM_SEG];
  logic [SEG_W-1:0] pickedSeg;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSegReg
    always_ff @(posedge clk) begin
      if (rst)
        segReg[g] <= '0;
      else if (strobes.loadVec[g])
        segReg[g] <= busLow;
    end
  end

  // Read path sees pre-edge contents, so a same-cycle load is not forwarded
  always_comb begin
    pickedSeg = segReg[strobes.pickSel];
  end

  always_comb begin
    segOut      = strobes.driveEn ? pickedSeg : '0;
    segValid    = strobes.driveEn;
    logicalAddr = {segOut, offsetIn};
  end
endmodule

// File: rtl/segment_file_top.sv
module segment_file_top
  import seg_file_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              wrStrobe,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  busIn,
  input  logic [OFF_W-1:0]  offsetIn,
  output logic [SEG_W-1:0]  segOut,
  output logic              segValid,
  output logic [ADDR_W-1:0] logicalAddr
);
  segStrobe_t strobes;
  logic [SEG_W-1:0] busLow;

  assign busLow = busIn[SEG_W-1:0];

  seg_ctrl ctrl_i (
    .wrSel    (wrSel),
    .wrStrobe (wrStrobe),
    .rdSel    (rdSel),
    .rdEn     (rdEn),
    .strobes  (strobes)
  );

  seg_datapath dp_i (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .busLow      (busLow),
    .offsetIn    (offsetIn),
    .segOut      (segOut),
    .segValid    (segValid),
    .logicalAddr (logicalAddr)
  );
endmodule

// File: rtl/seg_file_chk.sv
module seg_file_chk
  import seg_file_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  wrSel,
  input logic              wrStrobe,
  input logic [SEL_W-1:0]  rdSel,
  input logic              rdEn,
  input logic [BUS_W-1:0]  busIn,
  input logic [OFF_W-1:0]  offsetIn,
  input logic [SEG_W-1:0]  segOut,
  input logic              segValid,
  input logic [ADDR_W-1:0] logicalAddr
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rdEn) |-> (segOut == '0));

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |=> (!(rdEn && rdSel == $past(wrSel)) || segOut == $past(busIn[SEG_W-1:0])));

  // R3
  no_stray_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrStrobe) && rdEn && $past(rdEn) && rdSel == $past(rdSel))
      |-> (segOut == $past(segOut)));

  // R5
  drive_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> segValid);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> (segOut == '0 && !segValid));

  // R7
  addr_join_chk: assert property (@(posedge clk) disable iff (rst)
    logicalAddr == {segOut, offsetIn});
endmodule

bind segment_file_top seg_file_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .wrSel       (wrSel),
  .wrStrobe    (wrStrobe),
  .rdSel       (rdSel),
  .rdEn        (rdEn),
  .busIn       (busIn),
  .offsetIn    (offsetIn),
  .segOut      (segOut),
  .segValid    (segValid),
  .logicalAddr (logicalAddr)
);

// File: tb/segment_file_top_tb_top.sv
module segment_file_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  wrSel;
  logic        wrStrobe;
  logic [1:0]  rdSel;
  logic        rdEn;
  logic [31:0] busIn;
  logic [31:0] offsetIn;
  logic [15:0] segOut;
  logic        segValid;
  logic [47:0] logicalAddr;

  int checks = 0;
  int failures = 0;
  logic [15:0] model [4];

  always #4 clk = ~clk;

  segment_file_top dut_i (
    .clk(clk), .rst(rst), .wrSel(wrSel), .wrStrobe(wrStrobe),
    .rdSel(rdSel), .rdEn(rdEn), .busIn(busIn), .offsetIn(offsetIn),
    .segOut(segOut), .segValid(segValid), .logicalAddr(logicalAddr)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeSeg(input logic [1:0] sel, input logic [31:0] data, input logic strobe);
    @(negedge clk);
    wrSel = sel; busIn = data; wrStrobe = strobe;
    @(negedge clk);
    wrStrobe = 1'b0; busIn = ~data;
  endtask

  task automatic readAll(input string req);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rdEn = 1'b1; rdSel = 2'(s); offsetIn = 32'hA5000000 + 32'(s * 7919);
      #1;
      chk(req, {32'd0, segOut}, {32'd0, model[s]});
      chk({req, "/R5 valid"}, {47'd0, segValid}, 48'd1);
      chk({req, "/R7 addr"}, logicalAddr, {model[s], offsetIn});
    end
    rdEn = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; wrSel = '0; wrStrobe = 1'b0; rdSel = '0; rdEn = 1'b0;
    busIn = 32'hFFFF_FFFF; offsetIn = '0;
    for (int s = 0; s < 4; s++) model[s] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: all registers zero after reset
    readAll("R1 reset");

    // R2 and R4: load each register over several rounds, with junk upper bus bits
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < 4; s++) begin
        logic [15:0] v;
        v = 16'(16'h1357 * (s + 1) + 16'h0F0F * r + 1);
        writeSeg(2'(s), {16'(16'hC3C3 ^ (r * 97 + s)), v}, 1'b1);
        model[s] = v;
        readAll("R2/R4 load");
      end
    end

    // R3: strobe low, bus and select varied, nothing changes
    for (int s = 0; s < 4; s++) begin
      writeSeg(2'(s), 32'hDEAD_BEEF ^ 32'(s), 1'b0);
    end
    readAll("R3 no strobe");

    // R6 and R7: read disabled, every read select
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rdEn = 1'b0; rdSel = 2'(s); offsetIn = 32'h0BAD_F00D + 32'(s);
      #1;
      chk("R6 idle seg", {32'd0, segOut}, 48'd0);
      chk("R6 idle valid", {47'd0, segValid}, 48'd0);
      chk("R7 idle addr", logicalAddr, {16'd0, offsetIn});
    end

    // R8: same-cycle load and read of the same register
    for (int s = 0; s < 4; s++) begin
      logic [15:0] nv;
      nv = 16'(16'h8001 + 16'h0111 * s);
      @(negedge clk);
      wrSel = 2'(s); busIn = {16'h7777, nv}; wrStrobe = 1'b1;
      rdEn = 1'b1; rdSel = 2'(s); offsetIn = 32'h1234_5678;
      #1;
      chk("R8 old value", {32'd0, segOut}, {32'd0, model[s]});
      @(negedge clk);
      wrStrobe = 1'b0;
      #1;
      model[s] = nv;
      chk("R8 new value", {32'd0, segOut}, {32'd0, nv});
      rdEn = 1'b0;
    end

    // R1: reset again after data is present
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int s = 0; s < 4; s++) model[s] = '0;
    readAll("R1 re-reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule